// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Core

This core executes a program built from one instruction only. Every instruction means the same thing. The core subtracts a memory word from a 16-bit two's-complement accumulator and keeps the difference. It then branches if that difference is negative; otherwise it falls through to the following instruction. Because there is no opcode, there is nothing to decode. The sign of the difference is the only control decision the core makes.

Code and data live in one memory, reached through a single synchronous read port. Read data returns one clock after the address is presented. An instruction is two consecutive words: the address of the operand, followed by the branch destination. Each instruction takes four clocks:

1. Fetch the operand address.
2. Fetch the branch destination.
3. Read the operand.
4. Subtract and update the accumulator and program counter.

Software builds every other operation, such as adding, copying or comparing, out of chains of this step.

When a taken branch lands on the address of the instruction that took it, the core stops and raises a halt flag. This gives the environment a clean end-of-program marker.

Top module: `sbn_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core clears `acc` and `pc` to zero and drops `halted`. After release, the first address presented on `mem_addr` is 0.
- R2: An instruction takes exactly four clocks, with `mem_addr` set as follows:
  - first clock: `pc`
  - second clock: `pc+1`
  - third clock: the operand address read from word `pc`
  - fourth clock: `pc`
- R3: At the end of an instruction, `acc` becomes `acc - M[operand address]`, taken modulo 2^16. No other event changes `acc`.
- R4: If bit 15 of the new `acc` is 1, `pc` loads the branch destination read from word `pc+1`.
- R5: If bit 15 of the new `acc` is 0, whether the result is zero or positive, `pc` advances by 2.
- R6: A taken branch whose destination equals the current `pc` sets `halted`. From then on `halted`, `pc` and `acc` hold until reset, and the last subtraction is still applied.
- R7: An operand address may point at an instruction word, so code is readable as data.
- R8: `pc` arithmetic wraps modulo 2^ADDR_W. A fall-through from address 2^ADDR_W-2 goes to address 0.
- R9: The sign comes from the truncated 16-bit result, not the true difference. For example, 0x7FFF minus 0xFFFF gives 0x8000, which counts as negative and branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Address to the shared code/data memory |
| mem_rdata | input | DATA_W | Read data, valid one clock after its address |
| acc | output | DATA_W | Accumulator |
| pc | output | ADDR_W | Program counter |
| halted | output | 1 | Program reached a self-branch |

## Verification
The bench goes after the corners of the sign test:
- A zero result must fall through. A core testing "less or equal" would jump instead.
- An overflow from 0x7FFF to 0x8000 must branch. A core that compared full-width values would fall through.

It also traces the address sequence inside one instruction. An off-by-one in the read latency would pick up the wrong operand and leave a wrong accumulator.

A program that uses its own instruction words as operands exposes any core that separates code from data.

A fall-through at the top of memory must wrap to zero.

After a self-branch, the bench holds the core for many clocks. A non-sticky halt would show up as moving `pc` or `acc`.

// File: rtl/sbn_core.sv
module sbn_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  typedef enum logic [2:0] {S_OPA, S_TGT, S_OPD, S_EXE, S_HALT} state_t;

  state_t            state;
  logic [ADDR_W-1:0] opa_q, tgt_q;
  logic [DATA_W-1:0] diff;
  logic              neg;

  assign diff   = acc - mem_rdata;
  assign neg    = diff[DATA_W-1];
  assign halted = (state == S_HALT);

  always_comb begin
    case (state)
      S_TGT:   mem_addr = pc + ONE;
      S_OPD:   mem_addr = opa_q;
      default: mem_addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_OPA;
      acc   <= '0;
      pc    <= '0;
      opa_q <= '0;
      tgt_q <= '0;
    end else begin
      case (state)
        S_OPA: state <= S_TGT;
        S_TGT: begin
          opa_q <= mem_rdata[ADDR_W-1:0];
          state <= S_OPD;
        end
        S_OPD: begin
          tgt_q <= mem_rdata[ADDR_W-1:0];
          state <= S_EXE;
        end
        S_EXE: begin
          acc <= diff;
          if (neg) begin
            pc    <= tgt_q;
            state <= (tgt_q == pc) ? S_HALT : S_OPA;
          end else begin
            pc    <= pc + TWO;
            state <= S_OPA;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/sbn_core_checker.sv
module sbn_core_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] pc,
  input logic              halted,
  input logic [2:0]        state,
  input logic [ADDR_W-1:0] tgt_q
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);
  localparam logic [2:0] ST_OPA = 3'd0;
  localparam logic [2:0] ST_TGT = 3'd1;
  localparam logic [2:0] ST_EXE = 3'd3;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (acc == '0 && pc == '0 && !halted && mem_addr == '0));

  a_r2_first_fetch: assert property (@(posedge clk) disable iff (rst)
    state == ST_OPA |-> mem_addr == pc);

  a_r2_second_fetch: assert property (@(posedge clk) disable iff (rst)
    state == ST_TGT |-> mem_addr == pc + ONE);

  a_r3_acc_only_in_exe: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && acc != $past(acc)) |-> $past(state) == ST_EXE);

  a_r3_difference: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state) == ST_EXE) |-> acc == DATA_W'($past(acc) - $past(mem_rdata)));

  a_r4_taken: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state) == ST_EXE && acc[DATA_W-1]) |-> pc == $past(tgt_q));

  a_r5_fall_through: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(state) == ST_EXE && !acc[DATA_W-1]) |-> pc == ADDR_W'($past(pc) + TWO));

  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc)));

  a_r6_halt_cause: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(halted)) |-> (acc[DATA_W-1] && pc == $past(pc)));

endmodule

bind sbn_core sbn_core_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .acc(acc), .pc(pc), .halted(halted), .state(state), .tgt_q(tgt_q)
);

// File: tb/sbn_core_test.sv
`timescale 1ns/1ps
module sbn_core_test;
  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] acc;
  logic [AW-1:0] pc;
  logic          halted;
  logic [DW-1:0] mem [256];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  sbn_core #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .acc(acc), .pc(pc), .halted(halted)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic boot();
    rst = 1'b1;
    step(2);
    chk("R1 acc", acc, 16'h0);
    chk("R1 pc", DW'(pc), 16'h0);
    chk("R1 halted", DW'(halted), 16'h0);
    rst = 1'b0;
    chk("R1 first address", DW'(mem_addr), 16'h0);
  endtask

  task automatic t_fetch_and_halt();
    clear_mem();
    mem[0] = 16'd10; mem[1] = 16'd0; mem[10] = 16'd5;
    boot();
    step(1); chk("R2 target fetch", DW'(mem_addr), 16'd1);
    step(1); chk("R2 operand read", DW'(mem_addr), 16'd10);
    step(1); chk("R2 exec address", DW'(mem_addr), 16'd0);
    step(1);
    chk("R3 acc 0-5", acc, 16'hFFFB);
    chk("R6 halted raised", DW'(halted), 16'h1);
    chk("R6 pc at self", DW'(pc), 16'h0);
    step(12);
    chk("R6 halted sticky", DW'(halted), 16'h1);
    chk("R6 acc frozen", acc, 16'hFFFB);
    chk("R6 pc frozen", DW'(pc), 16'h0);
    rst = 1'b1;
    step(1);
    chk("R1 reset after halt acc", acc, 16'h0);
    chk("R1 reset after halt flag", DW'(halted), 16'h0);
  endtask

  task automatic t_zero_falls_through();
    clear_mem();
    mem[0] = 16'd20; mem[1] = 16'd50;
    mem[2] = 16'd20; mem[3] = 16'd2;
    mem[4] = 16'd21; mem[5] = 16'd4;
    mem[20] = 16'd0; mem[21] = 16'd1;
    boot();
    step(4);
    chk("R5 zero result pc", DW'(pc), 16'd2);
    chk("R5 zero result acc", acc, 16'h0);
    step(4);
    chk("R5 zero again pc", DW'(pc), 16'd4);
    chk("R5 not halted", DW'(halted), 16'h0);
    step(4);
    chk("R4 self branch acc", acc, 16'hFFFF);
    chk("R6 halted at 4", DW'(halted), 16'h1);
  endtask

  task automatic t_arith_chain();
    clear_mem();
    mem[0] = 16'd30; mem[1] = 16'd100;
    mem[2] = 16'd31; mem[3] = 16'd100;
    mem[4] = 16'd32; mem[5] = 16'd40;
    mem[40] = 16'd33; mem[41] = 16'd40;
    mem[30] = 16'hFFF9; mem[31] = 16'd3; mem[32] = 16'd10; mem[33] = 16'd0;
    boot();
    step(4);
    chk("R3 acc 0-(-7)", acc, 16'd7);
    chk("R5 positive pc", DW'(pc), 16'd2);
    step(4);
    chk("R3 acc 7-3", acc, 16'd4);
    chk("R5 positive pc 4", DW'(pc), 16'd4);
    step(4);
    chk("R3 acc 4-10", acc, 16'hFFFA);
    chk("R4 branch pc", DW'(pc), 16'd40);
    chk("R6 far branch no halt", DW'(halted), 16'h0);
    step(4);
    chk("R6 halt at 40", DW'(halted), 16'h1);
    chk("R6 acc at 40", acc, 16'hFFFA);
  endtask

  task automatic t_overflow_sign();
    clear_mem();
    mem[0] = 16'd60; mem[1] = 16'd90;
    mem[2] = 16'd61; mem[3] = 16'd2;
    mem[60] = 16'h8001; mem[61] = 16'hFFFF;
    boot();
    step(4);
    chk("R9 acc 7FFF", acc, 16'h7FFF);
    chk("R9 positive pc", DW'(pc), 16'd2);
    step(4);
    chk("R9 wrapped acc", acc, 16'h8000);
    chk("R9 wrapped branches", DW'(halted), 16'h1);
  endtask

  task automatic t_code_as_data();
    clear_mem();
    mem[0] = 16'd1; mem[1] = 16'd6;
    mem[6] = 16'd6; mem[7] = 16'd8;
    mem[8] = 16'd9; mem[9] = 16'd8;
    boot();
    step(4);
    chk("R7 read own target acc", acc, 16'hFFFA);
    chk("R7 pc 6", DW'(pc), 16'd6);
    step(4);
    chk("R7 read own opa acc", acc, 16'hFFF4);
    chk("R7 pc 8", DW'(pc), 16'd8);
    step(4);
    chk("R7 final acc", acc, 16'hFFEC);
    chk("R7 halted", DW'(halted), 16'h1);
  endtask

  task automatic t_pc_wrap();
    clear_mem();
    mem[0] = 16'd51; mem[1] = 16'd254;
    mem[254] = 16'd52; mem[255] = 16'd100;
    mem[51] = 16'd1; mem[52] = 16'hFFFF;
    boot();
    step(4);
    chk("R4 jump to 254", DW'(pc), 16'd254);
    step(1);
    chk("R8 target word at 255", DW'(mem_addr), 16'd255);
    step(3);
    chk("R8 acc zero", acc, 16'h0);
    chk("R8 pc wrapped", DW'(pc), 16'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_fetch_and_halt();
    t_zero_falls_through();
    t_arith_chain();
    t_overflow_sign();
    t_code_as_data();
    t_pc_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule